// File: doc/BRIEF.md
# Per-Port Transmit Space Status Generator

This block watches the free space of every transmit FIFO in a multi-port physical-layer device and turns each count into a one-bit "space available" flag with hysteresis. A flag rises once the free byte count climbs to a programmable rise level. It drops once the count sinks to a programmable fall level. Between the two levels it keeps its previous value. The FIFOs themselves sit outside the block; only their free-byte counts come in.

The flags are published in three views at once. A direct vector carries one flag per port. A selected-port flag follows the port most recently chosen by the in-band address strobe of the write path. A polled flag answers a separate poll address bus through a two-stage pipeline. The link-layer side can poll any port in any order, even while it is writing packet data to a different port.

Top module: `tpa_status_gen`

## Requirements
- R1: A port's flag reads 1 after a rising edge at which its free count was at least `rise_lvl_i` and above `fall_lvl_i`.
- R2: A port's flag reads 0 after a rising edge at which its free count was at most `fall_lvl_i`.
- R3: When the free count lies strictly between `fall_lvl_i` and `rise_lvl_i` at an edge, the flag keeps its value across that edge.
- R4: Bit i of `direct_avail_o` is port i's flag, and it is registered once per rising edge from the inputs sampled at that edge.
- R5: A rising edge with `sel_stb_i` high stores `sel_addr_i` as the selected port. From that edge on, `sel_avail_o` shows that port's flag. `sel_avail_o` reads 0 when the stored address is not below NUM_PORTS.
- R6: `poll_addr_i` sampled at edge k is reflected in `poll_avail_o` after edge k+1, which then equals that port's flag as it stood after edge k. The poll address is independent of the selected port.
- R7: A sampled poll address not below NUM_PORTS gives `poll_avail_o` = 0 after the next edge.
- R8: While `rst_n` is low, every direct flag is 1, the selected port is 0, and `sel_avail_o` and `poll_avail_o` are 1, whatever the free counts are.
- R9: At an edge with `sel_stb_i` low, the selected port does not change, whatever `sel_addr_i` carries.
- R10: Free counts span 0 to FIFO_DEPTH inclusive. A count equal to FIFO_DEPTH (256 by default, in a 9-bit field) is compared like any other value.
- R11: When a count satisfies both the rise and the fall condition (for example with equal levels), the flag goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| free_bytes_i | input | NUM_PORTS*CNT_W | Free byte count per port; port i occupies bits [i*CNT_W +: CNT_W] |
| rise_lvl_i | input | CNT_W | Free count at or above which a flag rises |
| fall_lvl_i | input | CNT_W | Free count at or below which a flag falls |
| sel_stb_i | input | 1 | In-band address strobe from the write path |
| sel_addr_i | input | ADDR_W | In-band port address, taken when the strobe is high |
| poll_addr_i | input | ADDR_W | Poll address bus |
| direct_avail_o | output | NUM_PORTS | One flag per port |
| sel_avail_o | output | 1 | Flag of the selected port |
| poll_avail_o | output | 1 | Flag of the polled port, two-stage pipeline |

## Verification
The bench builds the block with four ports, a 256-byte depth and an 8-bit address. With these values the 9-bit count can carry the full-empty value 256. Both the selected-port and poll addresses can also point well past the last port, for example 9 or 250, which exercises the out-of-range handling. With only four ports, a short vector table can drive every flag through rise, fall and hold. In the same table, polling walks the ports in an irregular order while the selected port moves independently.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

  typedef enum logic [1:0] {
    LVL_HOLD  = 2'd0,
    LVL_SET   = 2'd1,
    LVL_CLEAR = 2'd2
  } lvl_act_e;

  // Width of a count that must hold 0..depth inclusive.
  function automatic int cnt_width(input int depth);
    return $clog2(depth + 1);
  endfunction

  // Hysteresis decision; the fall condition has priority (R11).
  function automatic lvl_act_e judge(input int unsigned room,
                                     input int unsigned on_at,
                                     input int unsigned off_at);
    if (room <= off_at)     return LVL_CLEAR;
    else if (room >= on_at) return LVL_SET;
    else                    return LVL_HOLD;
  endfunction

  function automatic logic apply_act(input lvl_act_e act, input logic cur);
    case (act)
      LVL_SET:   return 1'b1;
      LVL_CLEAR: return 1'b0;
      default:   return cur;
    endcase
  endfunction

endpackage

// File: rtl/tpa_hyst_cell.sv
module tpa_hyst_cell
  import tpa_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] room_i,
  input  logic [CNT_W-1:0] on_lvl_i,
  input  logic [CNT_W-1:0] off_lvl_i,
  output logic             flag_o
);

  lvl_act_e act;
  logic     flag_q;

  assign act = judge(32'(room_i), 32'(on_lvl_i), 32'(off_lvl_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b1;
    else        flag_q <= apply_act(act, flag_q);
  end

  assign flag_o = flag_q;

  // R1: reaching the rise level sets the flag
  p_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (room_i >= on_lvl_i && room_i > off_lvl_i) |=> flag_o);

  // R2 / R11: at or below the fall level clears the flag
  p_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (room_i <= off_lvl_i) |=> !flag_o);

  // R3: between levels the flag holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (room_i > off_lvl_i && room_i < on_lvl_i) |=> $stable(flag_o));

  // R8: reset forces the flag high
  p_reset_high_r8: assert property (@(posedge clk)
    !rst_n |=> flag_o);

endmodule

// File: rtl/tpa_view_mux.sv
module tpa_view_mux #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] flag_vec_i,
  input  logic                 sel_stb_i,
  input  logic [ADDR_W-1:0]    sel_addr_i,
  input  logic [ADDR_W-1:0]    poll_addr_i,
  output logic                 sel_avail_o,
  output logic                 poll_avail_o
);

  logic [ADDR_W-1:0] sel_q;
  logic [ADDR_W-1:0] poll_q;
  logic              sel_in_rng;
  logic              poll_in_rng;
  logic              sel_hit;
  logic              poll_hit;
  logic              poll_out_q;

  // Selected port register (R5, R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= '0;
    else if (sel_stb_i) sel_q <= sel_addr_i;
  end

  // Poll pipeline: address stage then result stage (R6)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q     <= '0;
      poll_out_q <= 1'b1;
    end else begin
      poll_q     <= poll_addr_i;
      poll_out_q <= poll_hit;
    end
  end

  // Index by comparison so an out-of-range address simply misses (R5, R7)
  always_comb begin
    sel_hit     = 1'b0;
    poll_hit    = 1'b0;
    sel_in_rng  = 1'b0;
    poll_in_rng = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (32'(sel_q) == i) begin
        sel_hit    = flag_vec_i[i];
        sel_in_rng = 1'b1;
      end
      if (32'(poll_q) == i) begin
        poll_hit    = flag_vec_i[i];
        poll_in_rng = 1'b1;
      end
    end
  end

  assign sel_avail_o  = sel_hit;
  assign poll_avail_o = poll_out_q;

  // R5: a strobe loads the address
  p_sel_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb_i |=> (sel_q == $past(sel_addr_i)));

  // R5: an out-of-range selection reads low
  p_sel_oob_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_in_rng |-> !sel_avail_o);

  // R9: no strobe, no change of selection
  p_sel_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_stb_i |=> $stable(sel_q));

  // R6: in-range poll reports the flag seen one edge earlier
  p_poll_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_in_rng |=> (poll_avail_o == $past(poll_hit)));

  // R7: out-of-range poll reads low
  p_poll_oob_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_in_rng |=> !poll_avail_o);

endmodule

// File: rtl/tpa_status_gen.sv
module tpa_status_gen #(
  parameter  int NUM_PORTS  = 4,
  parameter  int FIFO_DEPTH = 256,
  parameter  int ADDR_W     = 8,
  localparam int CNT_W      = tpa_pkg::cnt_width(FIFO_DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS*CNT_W-1:0] free_bytes_i,
  input  logic [CNT_W-1:0]           rise_lvl_i,
  input  logic [CNT_W-1:0]           fall_lvl_i,
  input  logic                       sel_stb_i,
  input  logic [ADDR_W-1:0]          sel_addr_i,
  input  logic [ADDR_W-1:0]          poll_addr_i,
  output logic [NUM_PORTS-1:0]       direct_avail_o,
  output logic                       sel_avail_o,
  output logic                       poll_avail_o
);

  logic [NUM_PORTS-1:0] flag_vec;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    tpa_hyst_cell #(.CNT_W(CNT_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .room_i   (free_bytes_i[p*CNT_W +: CNT_W]),
      .on_lvl_i (rise_lvl_i),
      .off_lvl_i(fall_lvl_i),
      .flag_o   (flag_vec[p])
    );
  end

  tpa_view_mux #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_views (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_vec_i  (flag_vec),
    .sel_stb_i   (sel_stb_i),
    .sel_addr_i  (sel_addr_i),
    .poll_addr_i (poll_addr_i),
    .sel_avail_o (sel_avail_o),
    .poll_avail_o(poll_avail_o)
  );

  assign direct_avail_o = flag_vec;

  // R8: while reset is held every view reports space
  p_reset_views_r8: assert property (@(posedge clk)
    !rst_n |=> (&direct_avail_o && sel_avail_o && poll_avail_o));

endmodule

// File: tb/tb_tpa_status_gen.sv
module tb_tpa_status_gen;

  localparam int NP = 4;
  localparam int CW = 9;
  localparam int AW = 8;
  localparam int NROWS = 12;

  localparam int FREE_T [NROWS][NP] = '{
    '{200, 200, 200, 200}, '{ 10, 200,  63,  17}, '{ 64,  16,  63,  17},
    '{ 63,  17,  15,  64}, '{100,  17,  64,   0}, '{ 16, 100,  30, 256},
    '{ 17,  65,  30, 256}, '{  0,  15, 200,  40}, '{ 64,  64,  64,  64},
    '{ 32,  32,  32,  32}, '{256,   0, 256,   0}, '{ 65,   1,  15, 255}};
  localparam int STB_T  [NROWS] = '{1, 0, 1, 0, 1, 1, 0, 1, 0, 1, 1, 0};
  localparam int SELA_T [NROWS] = '{1, 0, 2, 3, 3, 0, 1, 9, 0, 2, 1, 0};
  localparam int POLL_T [NROWS] = '{0, 1, 2, 3, 0, 2, 3, 1, 250, 0, 2, 3};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] fr [NP];
  logic [NP*CW-1:0] fr_flat;
  logic [CW-1:0] rise_lvl, fall_lvl;
  logic          sel_stb;
  logic [AW-1:0] sel_addr, poll_addr;
  logic [NP-1:0] direct_avail;
  logic          sel_avail, poll_avail;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [NP-1:0] m_flag;
  int            m_sel;
  int            m_poll_a;
  logic          m_poll_o;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) fr_flat[i*CW +: CW] = fr[i];
  end

  tpa_status_gen #(.NUM_PORTS(NP), .FIFO_DEPTH(256), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .free_bytes_i(fr_flat),
    .rise_lvl_i(rise_lvl), .fall_lvl_i(fall_lvl),
    .sel_stb_i(sel_stb), .sel_addr_i(sel_addr), .poll_addr_i(poll_addr),
    .direct_avail_o(direct_avail), .sel_avail_o(sel_avail),
    .poll_avail_o(poll_avail));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    // poll result uses flags as they stood before this edge
    m_poll_o = (m_poll_a < NP) ? m_flag[m_poll_a] : 1'b0;
    m_poll_a = int'(poll_addr);
    for (int i = 0; i < NP; i++) begin
      if (fr[i] > fall_lvl) begin
        if (fr[i] >= rise_lvl) m_flag[i] = 1'b1;
      end else begin
        m_flag[i] = 1'b0;
      end
    end
    if (sel_stb) m_sel = int'(sel_addr);
    chk("R4 direct vector", 32'(direct_avail), 32'(m_flag));
    chk("R5 selected flag", 32'(sel_avail), (m_sel < NP) ? 32'(m_flag[m_sel]) : 32'd0);
    chk("R6 polled flag", 32'(poll_avail), 32'(m_poll_o));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) fr[i] = '0;
    rise_lvl = 9'd64; fall_lvl = 9'd16;
    sel_stb = 1'b1; sel_addr = 8'd3; poll_addr = 8'd2;
    m_flag = '1; m_sel = 0; m_poll_a = 0; m_poll_o = 1'b1;

    // R8: reset state with empty counts on every port
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset direct", 32'(direct_avail), 32'hF);
    chk("R8 reset selected", 32'(sel_avail), 32'd1);
    chk("R8 reset polled", 32'(poll_avail), 32'd1);
    rst_n = 1'b1;
    sel_stb = 1'b0; poll_addr = 8'd0;

    // vector table
    for (int r = 0; r < NROWS; r++) begin
      for (int i = 0; i < NP; i++) fr[i] = CW'(FREE_T[r][i]);
      sel_stb   = (STB_T[r] != 0);
      sel_addr  = AW'(SELA_T[r]);
      poll_addr = AW'(POLL_T[r]);
      tick();
    end

    // hysteresis on port 0
    rise_lvl = 9'd100; fall_lvl = 9'd20; sel_stb = 1'b0; poll_addr = 8'd0;
    fr[1] = 9'd200; fr[2] = 9'd200; fr[3] = 9'd200;
    fr[0] = 9'd20;  tick(); chk("R2 fall at level", 32'(direct_avail[0]), 0);
    fr[0] = 9'd21;  tick(); chk("R3 hold low above fall", 32'(direct_avail[0]), 0);
    fr[0] = 9'd99;  tick(); chk("R3 hold low below rise", 32'(direct_avail[0]), 0);
    fr[0] = 9'd100; tick(); chk("R1 rise at level", 32'(direct_avail[0]), 1);
    fr[0] = 9'd50;  tick(); chk("R3 hold high", 32'(direct_avail[0]), 1);
    fr[0] = 9'd21;  tick(); chk("R3 hold high near fall", 32'(direct_avail[0]), 1);
    fr[0] = 9'd20;  tick(); chk("R2 fall again", 32'(direct_avail[0]), 0);

    // R11: equal levels, clear wins
    rise_lvl = 9'd40; fall_lvl = 9'd40;
    fr[0] = 9'd41; tick(); chk("R11 above equal levels", 32'(direct_avail[0]), 1);
    fr[0] = 9'd40; tick(); chk("R11 clear wins at equal level", 32'(direct_avail[0]), 0);

    // R10: full-depth count
    rise_lvl = 9'd256; fall_lvl = 9'd255;
    fr[1] = 9'd200; tick(); chk("R10 below depth clears", 32'(direct_avail[1]), 0);
    fr[1] = 9'd256; tick(); chk("R10 count 256 rises", 32'(direct_avail[1]), 1);

    // R9: address without strobe is ignored
    rise_lvl = 9'd100; fall_lvl = 9'd20;
    sel_stb = 1'b1; sel_addr = 8'd1; tick();
    sel_stb = 1'b0; sel_addr = 8'd2; fr[2] = 9'd5; tick(); tick();
    chk("R9 no strobe keeps port 1", 32'(sel_avail), 1);
    sel_stb = 1'b1; tick(); sel_stb = 1'b0;
    chk("R5 strobe moves to low port 2", 32'(sel_avail), 0);
    sel_stb = 1'b1; sel_addr = 8'd7; tick(); sel_stb = 1'b0;
    chk("R5 out-of-range selection low", 32'(sel_avail), 0);

    // R7 / R6: poll out of range, then back in range
    poll_addr = 8'd200; tick(); tick();
    chk("R7 poll out of range", 32'(poll_avail), 0);
    poll_addr = 8'd3; tick();
    chk("R6 poll not yet updated", 32'(poll_avail), 0);
    tick();
    chk("R6 poll port 3 after two edges", 32'(poll_avail), 1);
    poll_addr = 8'd2; tick(); tick();
    chk("R6 poll port 2 low", 32'(poll_avail), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule